// File: doc/BRIEF.md
# Static Memory Wait-State Sequencer

This block sits between the access request stream of a static memory controller and the part that generates the strobe waveforms. For each access presented, it decides whether one idle cycle must be placed before the access may begin, reports the kind of idle cycle, and signals when the access is allowed to start. There are three reasons to hold an access back. The first is a move to a different chip select. The second is a pending configuration reload. The third is a read that directly follows a write with no hold cycle.

Each chip select has a shadow register set (setup, pulse, cycle, mode) that is written through a configuration strobe. The strobe waveform logic uses a working set instead. The working sets are refreshed from the shadows only during a chip-select wait or a reload wait. Writing a mode register arms the reload. Writes to the timing registers alone only stage new values. When a chip-select change and a pending reload coincide, they share the single chip-select wait.

Top module: `memws_sequencer`

## Requirements
- R1: After reset, every working set holds the reset values (setup 1, pulse 2, cycle 4, mode 3 by default) and no wait strobe is raised. The first access accepted after reset never waits, even if a reload is pending.
- R2: The configuration select encodes the register as follows: 0 is setup, 1 is pulse, 2 is cycle and 3 is mode. A write with select 0, 1 or 2 updates only the shadow copy. It arms no reload and changes no working value.
- R3: A write with select 3, for any chip select, arms a reload. The next access to the same chip select as the previous accepted access then gets one wait of type 2 (reload).
- R4: An access to a chip select other than that of the previous accepted access gets exactly one wait of type 1 (chip-select). That wait also clears a pending reload, so no reload wait follows.
- R5: A read that directly follows an accepted write flagged no-hold gets one wait of type 3 (early-read). Neither a read after a write with hold nor a write after a no-hold write waits.
- R6: At most one wait is inserted between two accesses. If several reasons apply, the chip-select change outranks the reload, and the reload outranks the early read.
- R7: In the wait cycle, ws_strobe is high for that single cycle and start_ok is low. In the following cycle, with the request still held, start_ok is high and ws_strobe is low. When no wait is inserted, ws_type is 0.
- R8: The working sets of all chip selects are loaded from the shadows at the clock edge that ends a chip-select or reload wait. An early-read wait loads nothing.
- R9: A select-3 write made in the same cycle as a consumed chip-select or reload wait keeps the reload armed for the access after the current one. The value it writes is not loaded by that wait.
- R10: The cur_* outputs show the working set of the chip select on req_cs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | An access is waiting to start |
| req_cs | input | CS_W | Chip select of the waiting access |
| req_write | input | 1 | Waiting access is a write |
| req_nohold | input | 1 | Write has no hold cycle (trailing edge set by the write strobe) |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_cs | input | CS_W | Chip select whose register is written |
| cfg_sel | input | 2 | Register select: 0 setup, 1 pulse, 2 cycle, 3 mode |
| cfg_wdata | input | DATA_W | Value written |
| ws_strobe | output | 1 | A wait cycle is being inserted now |
| ws_type | output | 2 | Wait type: 0 none, 1 chip-select, 2 reload, 3 early-read |
| start_ok | output | 1 | The waiting access begins this cycle |
| cur_setup | output | DATA_W | Working setup value for req_cs |
| cur_pulse | output | DATA_W | Working pulse value for req_cs |
| cur_cycle | output | DATA_W | Working cycle value for req_cs |
| cur_mode | output | DATA_W | Working mode value for req_cs |

## Verification
The bench targets the cases where wait reasons overlap. In one such case, a chip-select change meets both a pending reload and a no-hold write. A design with the wrong priority would report a reload or early-read wait there, and a design that stacks waits would add a second wait cycle. The bench also checks that timing-only writes neither cause a wait nor move the working values. It checks that an early-read wait leaves stale working values in place, which a design that reloads on every wait would get wrong. Finally, it checks that a mode write landing in a reload wait re-arms the reload. A design that clears the flag last would lose that reload, and one that loads the fresh value at once would show it a cycle early.

// File: rtl/memws_pkg.sv
package memws_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        WS_NONE   = 2'd0,
        WS_CS     = 2'd1,
        WS_RELOAD = 2'd2,
        WS_EARLY  = 2'd3
    } ws_kind_e;

    typedef enum logic [1:0] {
        SEL_SETUP = 2'd0,
        SEL_PULSE = 2'd1,
        SEL_CYCLE = 2'd2,
        SEL_MODE  = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        logic [DATA_W-1:0] setup;
        logic [DATA_W-1:0] pulse;
        logic [DATA_W-1:0] cycle;
        logic [DATA_W-1:0] mode;
    } tset_t;

    // Priority ladder: chip-select move, then reload, then early read.
    function automatic ws_kind_e pick_wait(
        input logic seen,
        input logic cs_moved,
        input logic reload_due,
        input logic prev_wr_nohold,
        input logic next_is_write
    );
        ws_kind_e k;
        if (!seen)                                k = WS_NONE;
        else if (cs_moved)                        k = WS_CS;
        else if (reload_due)                      k = WS_RELOAD;
        else if (prev_wr_nohold && !next_is_write) k = WS_EARLY;
        else                                      k = WS_NONE;
        return k;
    endfunction

endpackage

// File: rtl/memws_cfg_bank.sv
module memws_cfg_bank
    import memws_pkg::*;
#(
    parameter int    NUM_CS  = 4,
    parameter int    CS_W    = 2,
    parameter tset_t RST_SET = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CS_W-1:0]   cfg_cs,
    input  logic [1:0]        cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              load_en,
    input  logic [CS_W-1:0]   rd_cs,
    output tset_t             rd_set
);

    tset_t [NUM_CS-1:0] shadow_q;
    tset_t [NUM_CS-1:0] work_q;

    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
        logic hit;
        assign hit = cfg_we && (cfg_cs == CS_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                shadow_q[g] <= RST_SET;
            end else if (hit) begin
                case (cfg_sel_e'(cfg_sel))
                    SEL_SETUP: shadow_q[g].setup <= cfg_wdata;
                    SEL_PULSE: shadow_q[g].pulse <= cfg_wdata;
                    SEL_CYCLE: shadow_q[g].cycle <= cfg_wdata;
                    default:   shadow_q[g].mode  <= cfg_wdata;
                endcase
            end
        end

        always_ff @(posedge clk) begin
            if (rst)          work_q[g] <= RST_SET;
            else if (load_en) work_q[g] <= shadow_q[g];
        end
    end

    assign rd_set = work_q[rd_cs];

    AST_WORK_HOLD: assert property (@(posedge clk) disable iff (rst)
        !load_en |=> $stable(work_q)); // R8

    AST_SHADOW_SETUP: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_sel == SEL_SETUP) |=> (shadow_q[$past(cfg_cs)].setup == $past(cfg_wdata))); // R2

endmodule

// File: rtl/memws_decide.sv
module memws_decide
    import memws_pkg::*;
#(
    parameter int CS_W = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    input  logic [CS_W-1:0] req_cs,
    input  logic            req_write,
    input  logic            req_nohold,
    input  logic            cfg_we,
    input  logic [1:0]      cfg_sel,
    output logic            ws_strobe,
    output ws_kind_e        ws_kind,
    output logic            start_ok,
    output logic            load_en
);

    logic            seen_q;
    logic [CS_W-1:0] last_cs_q;
    logic            last_wnh_q;
    logic            pend_q;
    logic            taken_q;
    logic            mode_wr;
    ws_kind_e        want;

    assign mode_wr = cfg_we && (cfg_sel == SEL_MODE);

    always_comb begin
        want = pick_wait(seen_q, req_cs != last_cs_q, pend_q, last_wnh_q, req_write);
    end

    assign ws_strobe = req_valid && !taken_q && (want != WS_NONE);
    assign ws_kind   = ws_strobe ? want : WS_NONE;
    assign start_ok  = req_valid && !ws_strobe;
    assign load_en   = ws_strobe && (want == WS_CS || want == WS_RELOAD);

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q     <= 1'b0;
            last_cs_q  <= '0;
            last_wnh_q <= 1'b0;
            taken_q    <= 1'b0;
        end else if (start_ok) begin
            seen_q     <= 1'b1;
            last_cs_q  <= req_cs;
            last_wnh_q <= req_write && req_nohold;
            taken_q    <= 1'b0;
        end else if (ws_strobe) begin
            taken_q    <= 1'b1;
        end
    end

    // A mode write wins over the clear, so it re-arms for the next access.
    always_ff @(posedge clk) begin
        if (rst)          pend_q <= 1'b0;
        else if (mode_wr) pend_q <= 1'b1;
        else if (load_en) pend_q <= 1'b0;
    end

    AST_ONE_WAIT: assert property (@(posedge clk) disable iff (rst)
        ws_strobe |=> !ws_strobe); // R6

    AST_WAIT_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        ws_strobe |-> !start_ok); // R7

    AST_FIRST_FREE: assert property (@(posedge clk) disable iff (rst)
        !seen_q |-> !ws_strobe); // R1

    AST_CS_WINS: assert property (@(posedge clk) disable iff (rst)
        (ws_strobe && req_cs != last_cs_q) |-> (ws_kind == WS_CS)); // R6

    AST_TIMING_NO_ARM: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_sel != SEL_MODE && !pend_q) |=> !pend_q); // R2

    AST_REARM: assert property (@(posedge clk) disable iff (rst)
        (load_en && mode_wr) |=> pend_q); // R9

    AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (load_en && !cfg_we) |=> !pend_q); // R4

endmodule

// File: rtl/memws_sequencer.sv
module memws_sequencer
    import memws_pkg::*;
#(
    parameter int NUM_CS    = 4,
    parameter int RST_SETUP = 1,
    parameter int RST_PULSE = 2,
    parameter int RST_CYCLE = 4,
    parameter int RST_MODE  = 3,
    localparam int CS_W     = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [CS_W-1:0]   req_cs,
    input  logic              req_write,
    input  logic              req_nohold,
    input  logic              cfg_we,
    input  logic [CS_W-1:0]   cfg_cs,
    input  logic [1:0]        cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic              ws_strobe,
    output logic [1:0]        ws_type,
    output logic              start_ok,
    output logic [DATA_W-1:0] cur_setup,
    output logic [DATA_W-1:0] cur_pulse,
    output logic [DATA_W-1:0] cur_cycle,
    output logic [DATA_W-1:0] cur_mode
);

    localparam tset_t RST_SET = '{
        setup: DATA_W'(RST_SETUP),
        pulse: DATA_W'(RST_PULSE),
        cycle: DATA_W'(RST_CYCLE),
        mode:  DATA_W'(RST_MODE)
    };

    ws_kind_e kind;
    logic     load_en;
    tset_t    cur_set;

    memws_decide #(.CS_W(CS_W)) u_decide (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_cs     (req_cs),
        .req_write  (req_write),
        .req_nohold (req_nohold),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .ws_strobe  (ws_strobe),
        .ws_kind    (kind),
        .start_ok   (start_ok),
        .load_en    (load_en)
    );

    memws_cfg_bank #(.NUM_CS(NUM_CS), .CS_W(CS_W), .RST_SET(RST_SET)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_cs    (cfg_cs),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .load_en   (load_en),
        .rd_cs     (req_cs),
        .rd_set    (cur_set)
    );

    assign ws_type   = kind;
    assign cur_setup = cur_set.setup;
    assign cur_pulse = cur_set.pulse;
    assign cur_cycle = cur_set.cycle;
    assign cur_mode  = cur_set.mode;

    AST_TYPE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !ws_strobe |-> (ws_type == 2'd0)); // R7

endmodule

// File: tb/memws_sequencer_tb.sv
module memws_sequencer_tb;

    localparam int CLK_P = 10;
    localparam int N_VEC = 31;

    typedef struct packed {
        logic       v;
        logic [1:0] cs;
        logic       wr;
        logic       nh;
        logic       we;
        logic [1:0] wcs;
        logic [1:0] wsel;
        logic [7:0] wd;
        logic       es;
        logic [1:0] et;
        logic       eo;
        logic [7:0] esu;
    } vec_t;

    function automatic vec_t mk(int v, int cs, int wr, int nh, int we, int wcs, int wsel,
                                int wd, int es, int et, int eo, int esu);
        vec_t r;
        r.v = v[0]; r.cs = cs[1:0]; r.wr = wr[0]; r.nh = nh[0];
        r.we = we[0]; r.wcs = wcs[1:0]; r.wsel = wsel[1:0]; r.wd = wd[7:0];
        r.es = es[0]; r.et = et[1:0]; r.eo = eo[0]; r.esu = esu[7:0];
        return r;
    endfunction

    localparam vec_t VECS [N_VEC] = '{
        mk(1,0,0,0, 0,0,0,0,  0,0,1, 1),   // 0 first access
        mk(0,0,0,0, 1,2,0,9,  0,0,0, 1),   // 1 timing write cs2
        mk(1,0,0,0, 0,0,0,0,  0,0,1, 1),   // 2 no reload
        mk(0,0,0,0, 1,2,3,5,  0,0,0, 1),   // 3 mode write cs2
        mk(1,0,0,0, 0,0,0,0,  1,2,0, 1),   // 4 reload wait
        mk(1,0,0,0, 0,0,0,0,  0,0,1, 1),   // 5 start
        mk(1,2,0,0, 0,0,0,0,  1,1,0, 9),   // 6 cs change
        mk(1,2,0,0, 0,0,0,0,  0,0,1, 9),   // 7
        mk(1,2,1,1, 0,0,0,0,  0,0,1, 9),   // 8 no-hold write
        mk(1,2,0,0, 0,0,0,0,  1,3,0, 9),   // 9 early read
        mk(1,2,0,0, 0,0,0,0,  0,0,1, 9),   // 10
        mk(1,2,1,0, 0,0,0,0,  0,0,1, 9),   // 11 write with hold
        mk(1,2,0,0, 0,0,0,0,  0,0,1, 9),   // 12 read, no wait
        mk(1,2,1,1, 0,0,0,0,  0,0,1, 9),   // 13
        mk(1,2,1,1, 0,0,0,0,  0,0,1, 9),   // 14 write after write
        mk(0,0,0,0, 1,1,0,7,  0,0,0, 1),   // 15 timing write cs1
        mk(1,2,0,0, 0,0,0,0,  1,3,0, 9),   // 16 early read, no load
        mk(1,2,0,0, 0,0,0,0,  0,0,1, 9),   // 17
        mk(1,1,0,0, 0,0,0,0,  1,1,0, 1),   // 18 stale value seen
        mk(1,1,0,0, 0,0,0,0,  0,0,1, 7),   // 19 loaded value seen
        mk(1,1,1,1, 0,0,0,0,  0,0,1, 7),   // 20
        mk(0,0,0,0, 1,3,3,0,  0,0,0, 1),   // 21 mode write cs3
        mk(1,0,0,0, 0,0,0,0,  1,1,0, 1),   // 22 all three reasons
        mk(1,0,0,0, 0,0,0,0,  0,0,1, 1),   // 23
        mk(1,0,0,0, 0,0,0,0,  0,0,1, 1),   // 24 no extra reload
        mk(0,0,0,0, 1,0,0,32, 0,0,0, 1),   // 25
        mk(0,0,0,0, 1,0,3,6,  0,0,0, 1),   // 26 arm
        mk(1,0,0,0, 1,1,3,1,  1,2,0, 1),   // 27 reload + re-arm
        mk(1,0,0,0, 0,0,0,0,  0,0,1, 32),  // 28
        mk(1,0,0,0, 0,0,0,0,  1,2,0, 32),  // 29 re-armed reload
        mk(1,0,0,0, 0,0,0,0,  0,0,1, 32)   // 30
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0, req_write = 1'b0, req_nohold = 1'b0, cfg_we = 1'b0;
    logic [1:0] req_cs = '0, cfg_cs = '0, cfg_sel = '0;
    logic [7:0] cfg_wdata = '0;
    logic       ws_strobe, start_ok;
    logic [1:0] ws_type;
    logic [7:0] cur_setup, cur_pulse, cur_cycle, cur_mode;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_P/2) clk = ~clk;

    memws_sequencer u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_cs(req_cs),
        .req_write(req_write), .req_nohold(req_nohold), .cfg_we(cfg_we),
        .cfg_cs(cfg_cs), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .ws_strobe(ws_strobe), .ws_type(ws_type), .start_ok(start_ok),
        .cur_setup(cur_setup), .cur_pulse(cur_pulse), .cur_cycle(cur_cycle),
        .cur_mode(cur_mode)
    );

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic string row_tag(int i);
        if (i == 0)  return "R1 first access";
        if (i <= 2)  return "R2 timing-only write";
        if (i <= 5)  return "R3 reload wait";
        if (i <= 7)  return "R4 chip-select wait";
        if (i <= 17) return "R5 early read";
        if (i <= 19) return "R8 load on cs wait";
        if (i <= 24) return "R6 priority";
        return "R9 re-arm";
    endfunction

    task automatic drive(vec_t t);
        @(negedge clk);
        req_valid = t.v; req_cs = t.cs; req_write = t.wr; req_nohold = t.nh;
        cfg_we = t.we; cfg_cs = t.wcs; cfg_sel = t.wsel; cfg_wdata = t.wd;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        drive(mk(0,0,0,0, 0,0,0,0, 0,0,0,0));
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        #(CLK_P * 200000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        do_reset();
        // R1: reset state, idle outputs
        drive(mk(0,2,0,0, 0,0,0,0, 0,0,0,0));
        check("R1 strobe at reset", ws_strobe, 0);
        check("R7 type idle", ws_type, 0);
        check("R1 setup reset", cur_setup, 1);
        check("R1 pulse reset", cur_pulse, 2);
        check("R1 cycle reset", cur_cycle, 4);
        check("R1 mode reset", cur_mode, 3);

        for (int i = 0; i < N_VEC; i++) begin
            drive(VECS[i]);
            check(row_tag(i), ws_strobe, VECS[i].es);
            check(row_tag(i), ws_type, VECS[i].et);
            check("R7 start_ok", start_ok, VECS[i].eo);
            check("R10 cur_setup", cur_setup, VECS[i].esu);
        end

        // R10: full working set of cs1 after the loads above
        drive(mk(0,1,0,0, 0,0,0,0, 0,0,0,0));
        check("R10 mode cs1", cur_mode, 1);
        check("R10 pulse cs1", cur_pulse, 2);
        check("R10 cycle cs1", cur_cycle, 4);
        // R2: cs2 mode shadow 5 was loaded
        drive(mk(0,2,0,0, 0,0,0,0, 0,0,0,0));
        check("R2 mode cs2", cur_mode, 5);

        // R1: a pending reload does not hold back the first access after reset
        do_reset();
        drive(mk(0,3,0,0, 1,3,3,9, 0,0,0,0));
        drive(mk(1,3,0,0, 0,0,0,0, 0,0,0,0));
        check("R1 first access no wait", ws_strobe, 0);
        check("R1 first access starts", start_ok, 1);
        check("R1 working mode unchanged", cur_mode, 3);
        drive(mk(0,0,0,0, 0,0,0,0, 0,0,0,0));
        check("R1 strobe idle", ws_strobe, 0);

        finish_run();
    end

endmodule